// File: doc/BRIEF.md
# Pipeline Hazard Detection Unit

This block is the stall and flush controller for a five-stage in-order integer pipeline with fetch, decode, execute, memory and writeback stages. Conditional branches and register jumps are resolved in decode. The unit is purely combinational. It looks at the instruction in decode, which gives it the opcode, the function field and the two source register numbers. It also looks at the destination, write bit and load flag of the instruction in execute, the destination and write bit of the instruction in memory, and the taken signal from the decode-stage branch comparator. From these it drives the program-counter enable plus one hold and one clear line for each of the four pipeline registers.

Forwarding into the ALU operands and into the store-data path is assumed to exist elsewhere, so the unit stalls only in two cases. The first is a load in execute whose result is needed by an operand in execute on the next cycle. The second is a decode-stage comparison or register jump that needs a result that is still in flight. A jump, or a branch reported as taken, clears the fetch/decode register so the wrongly fetched instruction is dropped. A branch that is not taken keeps the fall-through instruction.

The unit settles on exactly one of four named verdicts each cycle. V_FLOW lets the pipeline advance. V_STALL_LOAD is a load-use bubble. V_STALL_RESOLVE is a bubble for a decode-stage consumer. V_REDIRECT drops the fetched instruction. There are no transitions between verdicts: each one is recomputed from the current inputs.

Top module: `hzd_unit`

## Requirements
- R1: With every input at zero, which is a shift-left of register 0, the outputs are pc_en=1, pr_hold=0 and pr_clear=0.
- R2: A source register number of 0 never causes a stall, even when an in-flight writer also targets register 0.
- R3: A stall drives pc_en=0, pr_hold=4'b0001 (bit 0 is fetch/decode) and pr_clear=4'b0010 (bit 1 is decode/execute). It leaves every other hold and clear bit at 0. A stall is taken when the execute instruction has write=1 and load=1 and its destination equals a source that is consumed in execute.
- R4: An execute-consumed source that matches a non-load writer in execute, or any writer in memory, does not stall. The store-data source (rt of a store) never stalls, even when the instruction in execute is a load.
- R5: A source consumed in decode stalls when it matches the destination of an execute or memory instruction whose write bit is 1. The decode consumers are the rs and rt of beq (op 0x04) and bne (0x05), the rs of blez (0x06), bgtz (0x07) and the regimm group (0x01), and the rs of jr (op 0, funct 0x08) and jalr (funct 0x09).
- R6: A writer whose write bit is 0 never causes a stall, whatever its destination or load flag.
- R7: With no stall, j (0x02), jal (0x03), jr and jalr drive pr_clear=4'b0001 with pc_en=1 and pr_hold=0.
- R8: With no stall, a conditional branch with br_taken=1 drives pr_clear=4'b0001. With br_taken=0 it clears nothing. br_taken has no effect on any other instruction.
- R9: When a stall and a control redirect coincide, the stall wins: pr_clear[0] stays 0 and pr_hold[0] is 1.
- R10: Source use is decoded as follows. R-type (op 0): both rs and rt are used in execute, except the shifts sll, srl and sra (funct 0x00, 0x02, 0x03), which use only rt. Immediate ALU ops 0x08 to 0x0E and loads 0x20 to 0x27 use rs. Stores 0x28 to 0x2F use rs as the address and rt as store data. lui (0x0F) and all other opcodes use no source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_opcode | input | 6 | Opcode of the instruction in decode |
| id_funct | input | 6 | Function field of the instruction in decode |
| id_rs | input | 5 | First source register number in decode |
| id_rt | input | 5 | Second source register number in decode |
| ex_dst | input | 5 | Destination register of the instruction in execute |
| ex_wr | input | 1 | Register-write bit of the instruction in execute |
| ex_load | input | 1 | Instruction in execute is a load |
| mem_dst | input | 5 | Destination register of the instruction in memory |
| mem_wr | input | 1 | Register-write bit of the instruction in memory |
| br_taken | input | 1 | Outcome of the decode-stage branch comparator |
| pc_en | output | 1 | Program counter may advance |
| pr_hold | output | 4 | Per pipeline register hold; bit 0 fetch/decode up to bit 3 memory/writeback |
| pr_clear | output | 4 | Per pipeline register clear to an all-zero no-op; same bit order |

## Verification
The bench sweeps every decoded instruction class against all combinations of a four-register subset for both sources and both in-flight destinations, every write and load flag, and both branch outcomes. Each result is compared with an arithmetic model of the rules above. The sweep targets several corner cases, each with a visible failure mode. Register 0 aliasing would show up as spurious stalls. A unit that forgot forwarding, or treated store data as an execute operand, would stall where none is needed. A design that ignored the memory stage for decode-stage compares would let a branch use a stale value. Letting a flush override a stall would destroy the held branch, and flushing on a not-taken branch would drop the correct fall-through instruction. A shift that used its rs field would stall on a field it never reads.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    localparam int OP_W  = 6;
    localparam int FN_W  = 6;

    // When a source operand is consumed
    typedef enum logic [1:0] {
        USE_NONE = 2'd0,
        USE_EX   = 2'd1,
        USE_ID   = 2'd2,
        USE_MEM  = 2'd3
    } use_t;

    // Control-flow class of the decode instruction
    typedef enum logic [1:0] {
        CF_NONE   = 2'd0,
        CF_BRANCH = 2'd1,
        CF_JUMP   = 2'd2
    } cf_t;

    // Per-cycle verdict of the unit
    typedef enum logic [1:0] {
        V_FLOW          = 2'd0,
        V_STALL_LOAD    = 2'd1,
        V_STALL_RESOLVE = 2'd2,
        V_REDIRECT      = 2'd3
    } verdict_t;

    localparam logic [OP_W-1:0] OP_SPECIAL = 6'h00;
    localparam logic [OP_W-1:0] OP_REGIMM  = 6'h01;
    localparam logic [OP_W-1:0] OP_J       = 6'h02;
    localparam logic [OP_W-1:0] OP_JAL     = 6'h03;
    localparam logic [OP_W-1:0] OP_BEQ     = 6'h04;
    localparam logic [OP_W-1:0] OP_BNE     = 6'h05;
    localparam logic [OP_W-1:0] OP_BLEZ    = 6'h06;
    localparam logic [OP_W-1:0] OP_BGTZ    = 6'h07;
    localparam logic [OP_W-1:0] OP_LUI     = 6'h0F;

    localparam logic [2:0] GRP_IMM   = 3'b001;
    localparam logic [2:0] GRP_LOAD  = 3'b100;
    localparam logic [2:0] GRP_STORE = 3'b101;

    localparam logic [FN_W-1:0] FN_SLL  = 6'h00;
    localparam logic [FN_W-1:0] FN_SRL  = 6'h02;
    localparam logic [FN_W-1:0] FN_SRA  = 6'h03;
    localparam logic [FN_W-1:0] FN_JR   = 6'h08;
    localparam logic [FN_W-1:0] FN_JALR = 6'h09;

endpackage

// File: rtl/hzd_decode.sv
module hzd_decode
    import hzd_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    input  logic [FN_W-1:0] funct,
    output use_t            rs_use,
    output use_t            rt_use,
    output cf_t             cf
);

    always_comb begin
        rs_use = USE_NONE;
        rt_use = USE_NONE;
        cf     = CF_NONE;
        unique case (opcode)
            OP_SPECIAL: begin
                unique case (funct)
                    FN_JR, FN_JALR: begin
                        rs_use = USE_ID;
                        cf     = CF_JUMP;
                    end
                    FN_SLL, FN_SRL, FN_SRA: begin
                        rt_use = USE_EX;
                    end
                    default: begin
                        rs_use = USE_EX;
                        rt_use = USE_EX;
                    end
                endcase
            end
            OP_REGIMM, OP_BLEZ, OP_BGTZ: begin
                rs_use = USE_ID;
                cf     = CF_BRANCH;
            end
            OP_BEQ, OP_BNE: begin
                rs_use = USE_ID;
                rt_use = USE_ID;
                cf     = CF_BRANCH;
            end
            OP_J, OP_JAL: begin
                cf = CF_JUMP;
            end
            OP_LUI: begin
                rs_use = USE_NONE;
            end
            default: begin
                unique case (opcode[OP_W-1:OP_W-3])
                    GRP_IMM, GRP_LOAD: rs_use = USE_EX;
                    GRP_STORE: begin
                        rs_use = USE_EX;
                        rt_use = USE_MEM;
                    end
                    default: rs_use = USE_NONE;
                endcase
            end
        endcase
    end

endmodule

// File: rtl/hzd_match.sv
module hzd_match
    import hzd_pkg::*;
#(
    parameter int REG_W = 5,
    parameter int N_SRC = 2
) (
    input  logic [N_SRC-1:0][REG_W-1:0] src,
    input  use_t                        src_use [N_SRC],
    input  logic [REG_W-1:0]            ex_dst,
    input  logic                        ex_wr,
    input  logic                        ex_load,
    input  logic [REG_W-1:0]            mem_dst,
    input  logic                        mem_wr,
    output logic                        need_resolve,
    output logic                        need_load
);

    logic [N_SRC-1:0] res_v;
    logic [N_SRC-1:0] ld_v;

    for (genvar s = 0; s < N_SRC; s++) begin : g_src
        logic live, hit_ex, hit_mem;
        always_comb begin
            live    = |src[s];
            hit_ex  = live && ex_wr  && (src[s] == ex_dst);
            hit_mem = live && mem_wr && (src[s] == mem_dst);
            // decode-stage consumers see no forwarding
            res_v[s] = (src_use[s] == USE_ID) && (hit_ex || hit_mem);
            // execute consumers only miss a load still in execute
            ld_v[s]  = (src_use[s] == USE_EX) && hit_ex && ex_load;
        end
    end

    assign need_resolve = |res_v;
    assign need_load    = |ld_v;

endmodule

// File: rtl/hzd_verdict.sv
module hzd_verdict
    import hzd_pkg::*;
#(
    parameter int N_PR = 4
) (
    input  logic            need_resolve,
    input  logic            need_load,
    input  cf_t             cf,
    input  logic            taken,
    output verdict_t        verdict,
    output logic            pc_en,
    output logic [N_PR-1:0] hold,
    output logic [N_PR-1:0] clear
);

    localparam int PR_IFID = 0;
    localparam int PR_IDEX = 1;

    // verdict selection: stalls outrank redirects
    always_comb begin
        if (need_resolve)
            verdict = V_STALL_RESOLVE;
        else if (need_load)
            verdict = V_STALL_LOAD;
        else if (cf == CF_JUMP || (cf == CF_BRANCH && taken))
            verdict = V_REDIRECT;
        else
            verdict = V_FLOW;
    end

    // outputs per verdict
    always_comb begin
        pc_en = 1'b1;
        hold  = '0;
        clear = '0;
        unique case (verdict)
            V_FLOW: begin
                pc_en = 1'b1;
            end
            V_STALL_LOAD, V_STALL_RESOLVE: begin
                pc_en          = 1'b0;
                hold[PR_IFID]  = 1'b1;
                clear[PR_IDEX] = 1'b1;
            end
            V_REDIRECT: begin
                clear[PR_IFID] = 1'b1;
            end
            default: pc_en = 1'b1;
        endcase
    end

endmodule

// File: rtl/hzd_unit.sv
module hzd_unit
    import hzd_pkg::*;
#(
    parameter int REG_W = 5,
    parameter int N_PR  = 4
) (
    input  logic [OP_W-1:0]  id_opcode,
    input  logic [FN_W-1:0]  id_funct,
    input  logic [REG_W-1:0] id_rs,
    input  logic [REG_W-1:0] id_rt,
    input  logic [REG_W-1:0] ex_dst,
    input  logic             ex_wr,
    input  logic             ex_load,
    input  logic [REG_W-1:0] mem_dst,
    input  logic             mem_wr,
    input  logic             br_taken,
    output logic             pc_en,
    output logic [N_PR-1:0]  pr_hold,
    output logic [N_PR-1:0]  pr_clear
);

    localparam int N_SRC = 2;

    use_t                        rs_use, rt_use;
    cf_t                         cf;
    use_t                        src_use [N_SRC];
    logic [N_SRC-1:0][REG_W-1:0] src;
    logic                        need_resolve, need_load;
    verdict_t                    verdict;

    hzd_decode u_decode (
        .opcode (id_opcode),
        .funct  (id_funct),
        .rs_use (rs_use),
        .rt_use (rt_use),
        .cf     (cf)
    );

    always_comb begin
        src[0]     = id_rs;
        src[1]     = id_rt;
        src_use[0] = rs_use;
        src_use[1] = rt_use;
    end

    hzd_match #(.REG_W(REG_W), .N_SRC(N_SRC)) u_match (
        .src          (src),
        .src_use      (src_use),
        .ex_dst       (ex_dst),
        .ex_wr        (ex_wr),
        .ex_load      (ex_load),
        .mem_dst      (mem_dst),
        .mem_wr       (mem_wr),
        .need_resolve (need_resolve),
        .need_load    (need_load)
    );

    hzd_verdict #(.N_PR(N_PR)) u_verdict (
        .need_resolve (need_resolve),
        .need_load    (need_load),
        .cf           (cf),
        .taken        (br_taken),
        .verdict      (verdict),
        .pc_en        (pc_en),
        .hold         (pr_hold),
        .clear        (pr_clear)
    );

endmodule

// File: rtl/hzd_unit_chk.sv
module hzd_unit_chk #(
    parameter int REG_W = 5,
    parameter int N_PR  = 4
) (
    input logic [5:0]       id_opcode,
    input logic [REG_W-1:0] id_rs,
    input logic [REG_W-1:0] id_rt,
    input logic             ex_wr,
    input logic             mem_wr,
    input logic             pc_en,
    input logic [N_PR-1:0]  pr_hold,
    input logic [N_PR-1:0]  pr_clear
);

    always_comb begin
        if (!$isunknown({id_opcode, id_rs, id_rt, ex_wr, mem_wr, pc_en, pr_hold, pr_clear})) begin
            AST_STALL_SHAPE: assert (pc_en || (pr_hold == N_PR'(1) && pr_clear == N_PR'(2))); // R3
            AST_STALL_BEATS_FLUSH: assert (!(pr_hold[0] && pr_clear[0])); // R9
            AST_ZERO_SRC_FREE: assert (!(id_rs == '0 && id_rt == '0) || pc_en); // R2
            AST_NO_WRITER_NO_STALL: assert (ex_wr || mem_wr || pc_en); // R6
            AST_JUMP_FLUSH: assert (!(pc_en && (id_opcode == 6'h02 || id_opcode == 6'h03)) || pr_clear == N_PR'(1)); // R7
        end
    end

endmodule

bind hzd_unit hzd_unit_chk #(.REG_W(REG_W), .N_PR(N_PR)) u_chk (
    .id_opcode (id_opcode),
    .id_rs     (id_rs),
    .id_rt     (id_rt),
    .ex_wr     (ex_wr),
    .mem_wr    (mem_wr),
    .pc_en     (pc_en),
    .pr_hold   (pr_hold),
    .pr_clear  (pr_clear)
);

// File: tb/hzd_unit_tb.sv
module hzd_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NK = 17;

    logic       clk = 1'b0;
    logic [5:0] id_opcode = '0, id_funct = '0;
    logic [4:0] id_rs = '0, id_rt = '0, ex_dst = '0, mem_dst = '0;
    logic       ex_wr = 1'b0, ex_load = 1'b0, mem_wr = 1'b0, br_taken = 1'b0;
    logic       pc_en;
    logic [3:0] pr_hold, pr_clear;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hzd_unit u_dut (
        .id_opcode (id_opcode), .id_funct (id_funct),
        .id_rs (id_rs), .id_rt (id_rt),
        .ex_dst (ex_dst), .ex_wr (ex_wr), .ex_load (ex_load),
        .mem_dst (mem_dst), .mem_wr (mem_wr), .br_taken (br_taken),
        .pc_en (pc_en), .pr_hold (pr_hold), .pr_clear (pr_clear)
    );

    // instruction kinds: opcode, funct, rs use, rt use, control class
    // use: 0 none, 1 execute, 2 decode, 3 store data; cls: 0 none, 1 branch, 2 jump
    int k_op [NK] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h02, 8'h03,
                      8'h04, 8'h05, 8'h06, 8'h07, 8'h08, 8'h0F, 8'h23, 8'h2B, 8'h3F};
    int k_fn [NK] = '{8'h00, 8'h02, 8'h20, 8'h08, 8'h09, 0, 0, 0,
                      0, 0, 0, 0, 0, 0, 0, 0, 0};
    int k_rs [NK] = '{0, 0, 1, 2, 2, 2, 0, 0, 2, 2, 2, 2, 1, 0, 1, 1, 0};
    int k_rt [NK] = '{1, 1, 1, 0, 0, 0, 0, 0, 2, 2, 0, 0, 0, 0, 0, 3, 0};
    int k_cf [NK] = '{0, 0, 0, 2, 2, 1, 2, 2, 1, 1, 1, 1, 0, 0, 0, 0, 0};

    function automatic logic [8:0] model(input int k, input int rs, input int rt,
                                         input int exd, input int exw, input int exl,
                                         input int md, input int mw, input int tk,
                                         output string tag);
        int src [2];
        int use_ [2];
        bit st = 0, any_hit = 0;
        src[0] = rs;  src[1] = rt;
        use_[0] = k_rs[k]; use_[1] = k_rt[k];
        for (int s = 0; s < 2; s++) begin
            bit hx, hm;
            hx = (src[s] != 0) && exw != 0 && src[s] == exd;
            hm = (src[s] != 0) && mw != 0 && src[s] == md;
            if (hx || hm) any_hit = 1;
            if (use_[s] == 2 && (hx || hm)) st = 1;
            if (use_[s] == 1 && hx && exl != 0) st = 1;
        end
        if (st) begin
            tag = (k_cf[k] != 0) ? "R9/R5" : "R3";
            return {1'b1 ^ 1'b1, 4'd1, 4'd2};
        end
        if (k_cf[k] == 2) begin tag = "R7"; return {1'b1, 4'd0, 4'd1}; end
        if (k_cf[k] == 1) begin
            tag = "R8";
            return (tk != 0) ? {1'b1, 4'd0, 4'd1} : {1'b1, 4'd0, 4'd0};
        end
        tag = any_hit ? "R4/R10" : "R6/R2";
        return {1'b1, 4'd0, 4'd0};
    endfunction

    task automatic apply(input int k, input int rs, input int rt, input int exd,
                         input int exw, input int exl, input int md, input int mw,
                         input int tk);
        logic [8:0] exp, got;
        string tag;
        id_opcode = 6'(k_op[k]); id_funct = 6'(k_fn[k]);
        id_rs = 5'(rs); id_rt = 5'(rt); ex_dst = 5'(exd); mem_dst = 5'(md);
        ex_wr = exw[0]; ex_load = exl[0]; mem_wr = mw[0]; br_taken = tk[0];
        #1;
        exp = model(k, rs, rt, exd, exw, exl, md, mw, tk, tag);
        got = {pc_en, pr_hold, pr_clear};
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            if (n_bad <= 20)
                $display("FAIL %s op=%h fn=%h rs=%0d rt=%0d exd=%0d w=%0d l=%0d md=%0d mw=%0d tk=%0d got=%b exp=%b",
                         tag, k_op[k], k_fn[k], rs, rt, exd, exw, exl, md, mw, tk, got, exp);
        end
        #1;
    endtask

    task automatic directed(input string tag, input logic [8:0] exp);
        logic [8:0] got;
        #1;
        got = {pc_en, pr_hold, pr_clear};
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%b exp=%b", tag, got, exp);
        end
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired got=timeout exp=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: all-zero inputs flow freely
        directed("R1", {1'b1, 4'd0, 4'd0});
        // R2: add $0,$0 against writers of $0 with load set
        id_opcode = 6'h00; id_funct = 6'h20; ex_dst = 0; ex_wr = 1; ex_load = 1; mem_wr = 1;
        directed("R2", {1'b1, 4'd0, 4'd0});
        // R6: beq on $3 while writers of $3 have write bit clear
        id_opcode = 6'h04; id_rs = 3; id_rt = 3; ex_dst = 3; mem_dst = 3; ex_wr = 0; mem_wr = 0; br_taken = 0;
        directed("R6", {1'b1, 4'd0, 4'd0});
        // R9: taken beq while its source is written by memory stage
        mem_wr = 1; br_taken = 1;
        directed("R9", {1'b0, 4'd1, 4'd2});
        // R4: store data from load in execute does not stall
        id_opcode = 6'h2B; id_rs = 1; id_rt = 2; ex_dst = 2; ex_wr = 1; ex_load = 1; mem_wr = 0;
        directed("R4", {1'b1, 4'd0, 4'd0});
        // R10: sll ignores rs matching a load in execute
        id_opcode = 6'h00; id_funct = 6'h00; id_rs = 2; id_rt = 1;
        directed("R10", {1'b1, 4'd0, 4'd0});

        // exhaustive sweep over a four-register subset: R3 R4 R5 R7 R8 R10
        for (int k = 0; k < NK; k++)
            for (int rs = 0; rs < 4; rs++)
                for (int rt = 0; rt < 4; rt++)
                    for (int exd = 0; exd < 4; exd++)
                        for (int md = 0; md < 4; md++)
                            for (int fl = 0; fl < 16; fl++)
                                apply(k, rs, rt, exd, fl & 1, (fl >> 1) & 1, md,
                                      (fl >> 2) & 1, (fl >> 3) & 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule